// File: doc/BRIEF.md
# Periodic Tick Down-Counter

This block produces a periodic tick from a 24-bit down-counter that runs on the core clock. Software sets it up through a small register bus with three registers. The reload register holds the period. The current-count register shows the live value. The control register holds a run bit, a tick-request enable bit and a sticky wrap flag. While running, the count drops by one on every clock. When it reaches zero, the next clock brings back the reload value, so one period lasts reload+1 clocks.

Each time the count steps from one to zero, the wrap flag is raised. If tick requests are enabled, a one-cycle request pulse is also issued. A halt input, asserted while the processor is stopped for debugging, freezes the count. The reload and current-count registers are not reset. Software must start the block in this order: program the reload value, write anything to the current-count register to zero it, then set the control bits.

Register map (word address on `bus_addr_i`):
- 0: control
- 1: reload
- 2: current count
- 3: unused, reads zero

Top module: `tick_timer`

## Requirements
- R1: After reset the control register reads zero (run bit 0, tick enable bit 1 and wrap flag bit 16 all clear), and `tick_irq_o` is low.
- R2: While the run bit is set, halt is low and the count is nonzero, the count at address 2 drops by exactly one per clock.
- R3: While running with a count of zero, the next clock loads the reload value. The reload register keeps only the low 24 bits of write data and reads back zero-extended.
- R4: A write of any data to address 2 makes the count zero on the next clock and clears the wrap flag.
- R5: The wrap flag (control bit 16) sets on the clock where the count steps from 1 to 0. A read strobe at address 0 returns the flag and clears it afterwards. If a read and a new wrap fall in the same cycle, the flag stays set.
- R6: `tick_irq_o` is high for exactly one cycle, the cycle in which the count first reads zero after a 1-to-0 step, and only when the tick enable bit was set. It is never high in two consecutive cycles.
- R7: While `halt_i` is high, the count holds its value, and neither the wrap flag nor a tick request is produced.
- R8: With a reload value of zero, a running counter stays at zero with no flag and no tick request.
- R9: With the run bit clear, the count holds its value.
- R10: Control writes affect only bits 0 and 1. Bit 16 is read-only, and all other control bits read zero, as does address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_i | input | 1 | Debug halt, freezes counting while high |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe (clears the wrap flag when reading address 0) |
| bus_addr_i | input | 2 | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the addressed register, combinational |
| tick_irq_o | output | 1 | One-cycle tick request pulse |

## Verification
The assertions assume the following about the inputs:
- At most one of the read and write strobes is high in any cycle.
- The address and data are stable around the clock edge.
- `halt_i` is a synchronous level and not a glitch.

The hold checks for halt and for a cleared run bit exclude cycles with a write to the count. The stimulus drives every input a short time after the falling edge, issues strobes one per bus task, and never overlaps a count write with a control write. The reference model ignores count and reload readback until software has written a value into them, because these registers hold no defined value after reset.

// File: rtl/tick_pkg.sv
package tick_pkg;
  localparam int CNT_W  = 24;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL   = 2'd0,
    REG_RELOAD = 2'd1,
    REG_COUNT  = 2'd2,
    REG_SPARE  = 2'd3
  } reg_addr_e;

  // next value of a running counter
  function automatic logic [CNT_W-1:0] count_step(input logic [CNT_W-1:0] cur,
                                                  input logic [CNT_W-1:0] rel);
    if (cur == '0) return rel;
    return cur - CNT_W'(1);
  endfunction

  // a running counter that holds one is about to wrap
  function automatic logic is_wrap(input logic [CNT_W-1:0] cur);
    return cur == CNT_W'(1);
  endfunction

  function automatic logic [DATA_W-1:0] pack_ctrl(input logic run, input logic ien,
                                                  input logic flag, input int run_bit,
                                                  input int ien_bit, input int flag_bit);
    logic [DATA_W-1:0] w;
    w = '0;
    w[run_bit]  = run;
    w[ien_bit]  = ien;
    w[flag_bit] = flag;
    return w;
  endfunction
endpackage

// File: rtl/tick_counter.sv
module tick_counter
  import tick_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         run_i,
  input  logic         wr_rel_i,
  input  logic         wr_cur_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] rel_o,
  output logic         wrap_o
);
  logic [W-1:0] cur_q;
  logic [W-1:0] rel_q;
  logic         step;

  assign step   = run_i && !wr_cur_i;
  assign wrap_o = step && is_wrap(cur_q);

  // no reset on purpose: both values are undefined until software writes them
  always_ff @(posedge clk) begin
    if (wr_rel_i) rel_q <= wdata_i;
    if (wr_cur_i)  cur_q <= '0;
    else if (step) cur_q <= count_step(cur_q, rel_q);
  end

  assign cur_o = cur_q;
  assign rel_o = rel_q;
endmodule

// File: rtl/tick_ctrl.sv
module tick_ctrl
  import tick_pkg::*;
#(
  parameter int DW       = DATA_W,
  parameter int RUN_BIT  = 0,
  parameter int IEN_BIT  = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctrl_i,
  input  logic          rd_ctrl_i,
  input  logic          wr_cur_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          wrap_i,
  output logic          run_en_o,
  output logic          ien_o,
  output logic          flag_o,
  output logic          irq_o
);
  logic run_q, ien_q, flag_q, irq_q;
  logic flag_clr;

  assign flag_clr = rd_ctrl_i || wr_cur_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      ien_q  <= 1'b0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_ctrl_i) begin
        run_q <= wdata_i[RUN_BIT];
        ien_q <= wdata_i[IEN_BIT];
      end
      // a new wrap outranks a clear in the same cycle
      if (wrap_i)        flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
      irq_q <= wrap_i && ien_q;
    end
  end

  assign run_en_o = run_q;
  assign ien_o    = ien_q;
  assign flag_o   = flag_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/tick_rdmux.sv
module tick_rdmux
  import tick_pkg::*;
#(
  parameter int W        = CNT_W,
  parameter int DW       = DATA_W,
  parameter int RUN_BIT  = 0,
  parameter int IEN_BIT  = 1,
  parameter int FLAG_BIT = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              run_i,
  input  logic              ien_i,
  input  logic              flag_i,
  input  logic [W-1:0]      cur_i,
  input  logic [W-1:0]      rel_i,
  output logic [DW-1:0]     rdata_o
);
  always_comb begin
    rdata_o = '0;
    case (reg_addr_e'(addr_i))
      REG_CTRL:   rdata_o = pack_ctrl(run_i, ien_i, flag_i, RUN_BIT, IEN_BIT, FLAG_BIT);
      REG_RELOAD: rdata_o = DW'(rel_i);
      REG_COUNT:  rdata_o = DW'(cur_i);
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_pkg::*;
#(
  parameter int W        = CNT_W,
  parameter int DW       = DATA_W,
  parameter int RUN_BIT  = 0,
  parameter int IEN_BIT  = 1,
  parameter int FLAG_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output logic [DW-1:0]     bus_rdata_o,
  output logic              tick_irq_o
);
  // decoded events, named for the checker
  logic wr_ctrl_w, rd_ctrl_w, wr_rel_w, wr_cur_w;
  logic run_w, en_w, ien_w, flag_w, wrap_w;
  logic [W-1:0] cur_w, rel_w;

  assign wr_ctrl_w = bus_wr_i && (bus_addr_i == REG_CTRL);
  assign rd_ctrl_w = bus_rd_i && (bus_addr_i == REG_CTRL);
  assign wr_rel_w  = bus_wr_i && (bus_addr_i == REG_RELOAD);
  assign wr_cur_w  = bus_wr_i && (bus_addr_i == REG_COUNT);
  assign run_w     = en_w && !halt_i;

  tick_counter #(.W(W)) cnt_i (
    .clk      (clk),
    .run_i    (run_w),
    .wr_rel_i (wr_rel_w),
    .wr_cur_i (wr_cur_w),
    .wdata_i  (bus_wdata_i[W-1:0]),
    .cur_o    (cur_w),
    .rel_o    (rel_w),
    .wrap_o   (wrap_w)
  );

  tick_ctrl #(.DW(DW), .RUN_BIT(RUN_BIT), .IEN_BIT(IEN_BIT)) ctl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ctrl_i (wr_ctrl_w),
    .rd_ctrl_i (rd_ctrl_w),
    .wr_cur_i  (wr_cur_w),
    .wdata_i   (bus_wdata_i),
    .wrap_i    (wrap_w),
    .run_en_o  (en_w),
    .ien_o     (ien_w),
    .flag_o    (flag_w),
    .irq_o     (tick_irq_o)
  );

  tick_rdmux #(.W(W), .DW(DW), .RUN_BIT(RUN_BIT), .IEN_BIT(IEN_BIT),
               .FLAG_BIT(FLAG_BIT)) mux_i (
    .addr_i  (bus_addr_i),
    .run_i   (en_w),
    .ien_i   (ien_w),
    .flag_i  (flag_w),
    .cur_i   (cur_w),
    .rel_i   (rel_w),
    .rdata_o (bus_rdata_o)
  );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int W = 24
) (
  input logic         clk,
  input logic         rst_n,
  input logic         halt_i,
  input logic         run_w,
  input logic         en_w,
  input logic         ien_w,
  input logic         wr_cur_w,
  input logic         wrap_w,
  input logic         flag_w,
  input logic [W-1:0] cur_w,
  input logic [W-1:0] rel_w,
  input logic         tick_irq_o
);
  // R2
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_w && !wr_cur_w && cur_w != '0) |=> (cur_w == $past(cur_w) - W'(1)));

  // R3
  reload_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_w && !wr_cur_w && cur_w == '0) |=> (cur_w == $past(rel_w)));

  // R4
  cur_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cur_w |=> (cur_w == '0 && !flag_w));

  // R5
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_w |=> flag_w);

  // R6
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_irq_o |=> !tick_irq_o);

  // R6
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_irq_o |-> ($past(wrap_w) && $past(ien_w) && cur_w == '0));

  // R7
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_i && !wr_cur_w) |=> ($stable(cur_w) && !tick_irq_o));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_w && !wr_cur_w) |=> $stable(cur_w));
endmodule

bind tick_timer tick_timer_chk #(.W(W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .halt_i     (halt_i),
  .run_w      (run_w),
  .en_w       (en_w),
  .ien_w      (ien_w),
  .wr_cur_w   (wr_cur_w),
  .wrap_w     (wrap_w),
  .flag_w     (flag_w),
  .cur_w      (cur_w),
  .rel_w      (rel_w),
  .tick_irq_o (tick_irq_o)
);

// File: tb/tick_timer_tb_top.sv
module tick_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        halt = 1'b0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  string req = "R1";
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  tick_timer dut_i (
    .clk(clk), .rst_n(rst_n), .halt_i(halt), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .tick_irq_o(irq)
  );

  // behavioural reference model
  bit          m_run, m_ien, m_flag, m_irq, m_cur_ok, m_rel_ok;
  int unsigned m_cur, m_rel;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_ien = 0; m_flag = 0; m_irq = 0; m_cur_ok = 0; m_rel_ok = 0;
    end else begin
      bit next_irq;
      bit next_flag;
      next_irq = 0;
      next_flag = m_flag;
      if (rd && addr == 2'd0) next_flag = 0;
      if (wr && addr == 2'd2) begin
        m_cur = 0; m_cur_ok = 1; next_flag = 0;
      end else if (m_run && !halt && m_cur_ok) begin
        if (m_cur == 0) begin
          m_cur = m_rel; m_cur_ok = m_rel_ok;
        end else begin
          if (m_cur == 1) begin next_flag = 1; next_irq = m_ien; end
          m_cur = m_cur - 1;
        end
      end
      if (wr && addr == 2'd0) begin m_run = wdata[0]; m_ien = wdata[1]; end
      if (wr && addr == 2'd1) begin m_rel = wdata & 32'h00FF_FFFF; m_rel_ok = 1; end
      m_flag = next_flag;
      m_irq  = next_irq;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit known;
      logic [31:0] exp;
      known = 1;
      case (addr)
        2'd0: exp = (32'(m_flag) << 16) | (32'(m_ien) << 1) | 32'(m_run);
        2'd1: begin exp = m_rel; known = m_rel_ok; end
        2'd2: begin exp = m_cur; known = m_cur_ok; end
        default: exp = 32'd0;
      endcase
      checks++;
      if (irq !== m_irq) begin
        errors++;
        $display("FAIL %s tick_irq actual=%0b expected=%0b at %0t", req, irq, m_irq, $time);
      end
      if (known) begin
        checks++;
        if (rdata !== exp) begin
          errors++;
          $display("FAIL %s rdata[addr %0d] actual=%h expected=%h at %0t",
                   req, addr, rdata, exp, $time);
        end
      end
    end
  end

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); #2;
    wr = 1; addr = a; wdata = d;
    @(negedge clk); #2;
    wr = 0; addr = 2'd2; wdata = '0;
  endtask

  task automatic bus_read(input logic [1:0] a);
    @(negedge clk); #2;
    rd = 1; addr = a;
    @(negedge clk); #2;
    rd = 0; addr = 2'd2;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: reset state of control and tick request
    repeat (3) @(negedge clk);
    #2 rst_n = 1;
    idle(3);
    // R10: upper bits and flag bit are not writable, spare address reads zero
    req = "R10";
    bus_write(2'd0, 32'hFFFF_FFFC);
    bus_read(2'd3);
    bus_read(2'd0);
    // R3: reload keeps 24 bits only
    req = "R3";
    bus_write(2'd1, 32'hFF12_3456);
    bus_read(2'd1);
    // R4: start-up order, clear the count with arbitrary data
    req = "R4";
    bus_write(2'd1, 32'd5);
    bus_write(2'd2, 32'h00AB_CDEF);
    idle(2);
    // R2 / R3 / R5 / R6: run with tick requests on
    req = "R2";
    bus_write(2'd0, 32'd3);
    idle(20);
    // R5: reading control returns the flag and clears it
    req = "R5";
    bus_read(2'd0);
    bus_read(2'd0);
    idle(4);
    // R7: halt freezes the count
    req = "R7";
    @(negedge clk); #2 halt = 1;
    idle(12);
    @(negedge clk); #2 halt = 0;
    idle(8);
    // R9: run bit clear holds the count
    req = "R9";
    bus_write(2'd0, 32'd2);
    idle(8);
    // R6: run without tick enable, flag only
    req = "R6";
    bus_write(2'd0, 32'd1);
    idle(14);
    // R6: shortest period, reload one
    bus_write(2'd1, 32'd1);
    bus_write(2'd0, 32'd3);
    idle(10);
    // R4: clear the count while the flag is set
    req = "R4";
    bus_write(2'd2, 32'hFFFF_FFFF);
    bus_read(2'd0);
    // R8: reload zero keeps the counter at zero
    req = "R8";
    bus_write(2'd1, 32'd0);
    bus_write(2'd2, 32'd7);
    idle(12);
    bus_read(2'd0);
    // R5: read strobes scattered across wraps
    req = "R5";
    bus_write(2'd1, 32'd2);
    for (int i = 0; i < 12; i++) bus_read(2'd0);
    // R3: long reload wraps through the top bits
    req = "R3";
    bus_write(2'd1, 32'h00FF_FFFF);
    bus_write(2'd2, 32'd0);
    idle(6);
    bus_read(2'd1);
    idle(4);
    finish_run();
  end
endmodule